// File: doc/BRIEF.md
# Two-Level Translation Lookaside Buffer

This block turns a virtual address into a physical address. A small first-level table is searched first. Behind it sits a larger second-level table. Both levels are fully associative and hold one valid bit, one virtual page number and one physical frame number per entry. Pages and frames are 1 KB, so the low ten address bits go straight through to the result.

A lookup finishes only when the first level holds the page. If the first level misses and the second level hits, the block copies the entry into the first level and then answers. If both levels miss, the block asks an external walker for the mapping through a request/acknowledge handshake. It writes the returned frame into both levels and answers in the same step. The two levels are kept inclusive: when the second level evicts a page, any copy of that page in the first level is dropped in the same cycle.

A flush strobe clears every entry of both levels in one cycle. The operating system raises it at each preemption. If a flush arrives while a walk is outstanding, the walk's result is not installed and the lookup answers with a miss flag. Four single-cycle event pulses (first-level hit, second-level hit, walk start, refill) are provided for statistics counters.

Top module: `tlb2_top`

The controller has three states:
- `ST_IDLE` accepts requests.
- `ST_L2FILL` answers after a second-level hit has been copied upward.
- `ST_WALK` waits for the walker.

The transitions are:
- `ST_IDLE`→`ST_L2FILL` on an accepted request that misses the first level and hits the second.
- `ST_IDLE`→`ST_WALK` on an accepted request that misses both levels.
- `ST_L2FILL`→`ST_IDLE` unconditionally.
- `ST_WALK`→`ST_IDLE` on `walk_ack`.

A request that hits the first level leaves the controller in `ST_IDLE`.

## Requirements
- R1: After reset both levels are empty, `req_ready` is 1 and every response, walk and event output is 0; the first lookup after reset therefore starts a walk.
- R2: A request accepted on clock edge E that hits the first level gives `resp_valid`=1 after E with `resp_paddr` = {frame, offset}, `resp_miss`=0, and a one-cycle `ev_l1_hit` pulse after E.
- R3: A request that misses the first level and hits the second gives `ev_l2_hit` for one cycle after the accepting edge E and `resp_valid` after edge E+1. The page is written into the first level, so an immediate repeat of the lookup hits the first level.
- R4: On a miss in both levels, `ev_walk` pulses after the accepting edge and `walk_req` rises with `walk_vpn` equal to the page, and both hold until `walk_ack`. The response, carrying `walk_pfn`, comes after the edge that samples `walk_ack`, together with an `ev_refill` pulse. The mapping is installed in both levels.
- R5: In each level an install uses the lowest-indexed invalid entry. When the level is full, the install replaces the entry at a round-robin pointer, which then advances by one and wraps after the last entry. A level's pointer moves only on a replacement in that level.
- R6: When a second-level install evicts a valid page, that page is also removed from the first level in the same cycle. The first-level victim is chosen after that removal.
- R7: A flush clears all entries of both levels in one cycle, and `req_ready` is 0 during a cycle in which flush is high.
- R8: A flush during `ST_WALK`, including in the cycle of `walk_ack`, cancels the install. The lookup then responds with `resp_miss`=1, and `ev_refill` does not pulse.
- R9: `req_ready` is 1 only in `ST_IDLE`, so no request is taken while a second-level fill or a walk is in progress.
- R10: The low 10 bits of `resp_paddr` equal the low 10 bits of the accepted `req_vaddr` in every translated response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Request accepted on this edge when high with req_valid |
| req_vaddr | input | VA_W | Virtual address to translate |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_paddr | output | PFN_W+OFF_W | Translated physical address |
| resp_miss | output | 1 | Response carries no translation (walk cancelled by flush) |
| walk_req | output | 1 | Walk requested for walk_vpn |
| walk_vpn | output | VA_W-OFF_W | Page number to be walked |
| walk_ack | input | 1 | Walker returns the mapping this cycle |
| walk_pfn | input | PFN_W | Frame number returned by the walker |
| flush | input | 1 | Invalidate every entry of both levels |
| ev_l1_hit | output | 1 | Pulse: lookup hit the first level |
| ev_l2_hit | output | 1 | Pulse: lookup hit the second level |
| ev_walk | output | 1 | Pulse: lookup missed both levels |
| ev_refill | output | 1 | Pulse: walk result installed |

## Verification
The bench builds the block with its default parameters:
- 32-bit virtual addresses and a 10-bit offset, giving a 22-bit page number.
- 16-bit frames.
- 12 first-level entries and 24 second-level entries.

Random page numbers are drawn from 40 values. That is more than the second level holds, so both levels fill up and round-robin replacement and back-invalidation are exercised often. About a tenth of the walks see a flush, some of them in the same cycle as the acknowledge. A directed sequence fills 24 pages, pulls page 0 back into the first level and then evicts it from the second level, which makes the inclusion path observable as a forced walk.

// File: rtl/tlb2_pkg.sv
package tlb2_pkg;

    localparam int TLB_VA_W  = 32;
    localparam int TLB_OFF_W = 10;
    localparam int TLB_PFN_W = 16;
    localparam int TLB_L1_N  = 12;
    localparam int TLB_L2_N  = 24;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_L2FILL = 2'd1,
        ST_WALK   = 2'd2
    } tlb_state_e;

endpackage

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int N  = 12,
    parameter int IW = 4
) (
    input  logic [N-1:0]  valid,
    input  logic [IW-1:0] ptr,
    output logic [IW-1:0] idx,
    output logic          full
);

    always_comb begin
        full = &valid;
        idx  = ptr;
        for (int i = N - 1; i >= 0; i--) begin
            if (!valid[i]) begin
                idx = IW'(i);
            end
        end
    end

endmodule

// File: rtl/tlb_level.sv
module tlb_level #(
    parameter int N     = 12,
    parameter int VPN_W = 22,
    parameter int PFN_W = 16,
    localparam int IW   = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_hit,
    output logic [PFN_W-1:0] lk_pfn,
    input  logic             wr_en,
    input  logic [VPN_W-1:0] wr_vpn,
    input  logic [PFN_W-1:0] wr_pfn,
    input  logic             inv_en,
    input  logic [VPN_W-1:0] inv_vpn,
    output logic             vic_valid,
    output logic [VPN_W-1:0] vic_vpn
);

    logic [N-1:0]     vld_q;
    logic [N-1:0]     vld_eff;
    logic [N-1:0]     hit_vec;
    logic [N-1:0]     inv_vec;
    logic [VPN_W-1:0] tag_q [N];
    logic [PFN_W-1:0] pfn_q [N];
    logic [IW-1:0]    ptr_q;
    logic [IW-1:0]    vidx;
    logic             full;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit_vec[g] = vld_q[g] && (tag_q[g] == lk_vpn);
        assign inv_vec[g] = inv_en && vld_q[g] && (tag_q[g] == inv_vpn);
    end

    assign vld_eff = vld_q & ~inv_vec;
    assign lk_hit  = |hit_vec;

    always_comb begin
        lk_pfn = '0;
        for (int i = 0; i < N; i++) begin
            if (hit_vec[i]) begin
                lk_pfn = lk_pfn | pfn_q[i];
            end
        end
    end

    tlb_victim #(.N(N), .IW(IW)) u_victim (
        .valid (vld_eff),
        .ptr   (ptr_q),
        .idx   (vidx),
        .full  (full)
    );

    assign vic_valid = vld_eff[vidx];
    assign vic_vpn   = tag_q[vidx];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            ptr_q <= '0;
        end else if (flush) begin
            vld_q <= '0;
        end else begin
            vld_q <= vld_eff;
            if (wr_en) begin
                vld_q[vidx] <= 1'b1;
                if (full) begin
                    ptr_q <= (ptr_q == IW'(N - 1)) ? '0 : ptr_q + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en && !flush) begin
            tag_q[vidx] <= wr_vpn;
            pfn_q[vidx] <= wr_pfn;
        end
    end

endmodule

// File: rtl/tlb2_top.sv
module tlb2_top
    import tlb2_pkg::*;
#(
    parameter int VA_W  = TLB_VA_W,
    parameter int OFF_W = TLB_OFF_W,
    parameter int PFN_W = TLB_PFN_W,
    parameter int L1_N  = TLB_L1_N,
    parameter int L2_N  = TLB_L2_N,
    localparam int VPN_W = VA_W - OFF_W,
    localparam int PA_W  = PFN_W + OFF_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_vaddr,
    output logic             resp_valid,
    output logic [PA_W-1:0]  resp_paddr,
    output logic             resp_miss,
    output logic             walk_req,
    output logic [VPN_W-1:0] walk_vpn,
    input  logic             walk_ack,
    input  logic [PFN_W-1:0] walk_pfn,
    input  logic             flush,
    output logic             ev_l1_hit,
    output logic             ev_l2_hit,
    output logic             ev_walk,
    output logic             ev_refill
);

    tlb_state_e       state_q, state_d;
    logic [VPN_W-1:0] vpn_q;
    logic [OFF_W-1:0] off_q;
    logic [PFN_W-1:0] pfn_q;
    logic             cancel_q;

    logic [VPN_W-1:0] req_vpn;
    logic [OFF_W-1:0] req_off;
    logic             accept;
    logic             install;
    logic             cancel_now;

    logic             l1_hit, l2_hit;
    logic [PFN_W-1:0] l1_pfn, l2_pfn;
    logic             l1_wr;
    logic [VPN_W-1:0] l1_wr_vpn;
    logic [PFN_W-1:0] l1_wr_pfn;
    logic             l2_vic_valid;
    logic [VPN_W-1:0] l2_vic_vpn;
    logic             unused_l1_vic_valid;
    logic [VPN_W-1:0] unused_l1_vic_vpn;

    assign req_vpn    = req_vaddr[VA_W-1:OFF_W];
    assign req_off    = req_vaddr[OFF_W-1:0];
    assign req_ready  = (state_q == ST_IDLE) && !flush;
    assign accept     = req_ready && req_valid;
    assign cancel_now = cancel_q || flush;
    assign install    = (state_q == ST_WALK) && walk_ack && !cancel_now;
    assign walk_req   = (state_q == ST_WALK);
    assign walk_vpn   = vpn_q;

    assign l1_wr     = install || (accept && !l1_hit && l2_hit);
    assign l1_wr_vpn = (state_q == ST_WALK) ? vpn_q : req_vpn;
    assign l1_wr_pfn = (state_q == ST_WALK) ? walk_pfn : l2_pfn;

    tlb_level #(.N(L1_N), .VPN_W(VPN_W), .PFN_W(PFN_W)) u_l1 (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .lk_vpn    (req_vpn),
        .lk_hit    (l1_hit),
        .lk_pfn    (l1_pfn),
        .wr_en     (l1_wr),
        .wr_vpn    (l1_wr_vpn),
        .wr_pfn    (l1_wr_pfn),
        .inv_en    (install && l2_vic_valid),
        .inv_vpn   (l2_vic_vpn),
        .vic_valid (unused_l1_vic_valid),
        .vic_vpn   (unused_l1_vic_vpn)
    );

    tlb_level #(.N(L2_N), .VPN_W(VPN_W), .PFN_W(PFN_W)) u_l2 (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .lk_vpn    (req_vpn),
        .lk_hit    (l2_hit),
        .lk_pfn    (l2_pfn),
        .wr_en     (install),
        .wr_vpn    (vpn_q),
        .wr_pfn    (walk_pfn),
        .inv_en    (1'b0),
        .inv_vpn   ('0),
        .vic_valid (l2_vic_valid),
        .vic_vpn   (l2_vic_vpn)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept && !l1_hit) begin
                    state_d = l2_hit ? ST_L2FILL : ST_WALK;
                end
            end
            ST_L2FILL: state_d = ST_IDLE;
            ST_WALK: begin
                if (walk_ack) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            resp_paddr <= '0;
            resp_miss  <= 1'b0;
            ev_l1_hit  <= 1'b0;
            ev_l2_hit  <= 1'b0;
            ev_walk    <= 1'b0;
            ev_refill  <= 1'b0;
            vpn_q      <= '0;
            off_q      <= '0;
            pfn_q      <= '0;
            cancel_q   <= 1'b0;
        end else begin
            resp_valid <= 1'b0;
            resp_miss  <= 1'b0;
            ev_l1_hit  <= 1'b0;
            ev_l2_hit  <= 1'b0;
            ev_walk    <= 1'b0;
            ev_refill  <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    cancel_q <= 1'b0;
                    if (accept) begin
                        vpn_q <= req_vpn;
                        off_q <= req_off;
                        pfn_q <= l2_pfn;
                        if (l1_hit) begin
                            resp_valid <= 1'b1;
                            resp_paddr <= {l1_pfn, req_off};
                            ev_l1_hit  <= 1'b1;
                        end else if (l2_hit) begin
                            ev_l2_hit <= 1'b1;
                        end else begin
                            ev_walk <= 1'b1;
                        end
                    end
                end
                ST_L2FILL: begin
                    resp_valid <= 1'b1;
                    resp_paddr <= {pfn_q, off_q};
                end
                ST_WALK: begin
                    if (walk_ack) begin
                        resp_valid <= 1'b1;
                        cancel_q   <= 1'b0;
                        if (cancel_now) begin
                            resp_miss  <= 1'b1;
                            resp_paddr <= '0;
                        end else begin
                            resp_paddr <= {walk_pfn, off_q};
                            ev_refill  <= 1'b1;
                        end
                    end else if (flush) begin
                        cancel_q <= 1'b1;
                    end
                end
                default: cancel_q <= 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/tlb2_chk.sv
module tlb2_chk #(
    parameter int VPN_W = 22
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_ready,
    input logic             resp_valid,
    input logic             resp_miss,
    input logic             walk_req,
    input logic [VPN_W-1:0] walk_vpn,
    input logic             walk_ack,
    input logic             flush,
    input logic             ev_l1_hit,
    input logic             ev_l2_hit,
    input logic             ev_walk,
    input logic             ev_refill
);

    a_r4_walk_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_req && !walk_ack) |=> (walk_req && $stable(walk_vpn)));

    a_r4_walk_after_miss: assert property (@(posedge clk) disable iff (!rst_n)
        ev_walk |-> walk_req);

    a_r4_refill_resp: assert property (@(posedge clk) disable iff (!rst_n)
        ev_refill |-> (resp_valid && !resp_miss));

    a_r3_l2_resp: assert property (@(posedge clk) disable iff (!rst_n)
        ev_l2_hit |=> (resp_valid && !resp_miss));

    a_r9_busy_walk: assert property (@(posedge clk) disable iff (!rst_n)
        walk_req |-> !req_ready);

    a_r7_flush_block: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !req_ready);

    a_r8_cancel_no_refill: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_req && flush) |=> !ev_refill);

    a_r8_miss_in_resp: assert property (@(posedge clk) disable iff (!rst_n)
        resp_miss |-> resp_valid);

    a_r2_one_event: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ev_l1_hit, ev_l2_hit, ev_walk, ev_refill}));

endmodule

bind tlb2_top tlb2_chk #(.VPN_W(VPN_W)) u_tlb2_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .resp_valid (resp_valid),
    .resp_miss  (resp_miss),
    .walk_req   (walk_req),
    .walk_vpn   (walk_vpn),
    .walk_ack   (walk_ack),
    .flush      (flush),
    .ev_l1_hit  (ev_l1_hit),
    .ev_l2_hit  (ev_l2_hit),
    .ev_walk    (ev_walk),
    .ev_refill  (ev_refill)
);

// File: tb/tlb2_top_tb_top.sv
`timescale 1ns/1ps
module tlb2_top_tb_top;

    localparam int VA_W  = 32;
    localparam int OFF_W = 10;
    localparam int PFN_W = 16;
    localparam int L1_N  = 12;
    localparam int L2_N  = 24;
    localparam int VPN_W = VA_W - OFF_W;
    localparam int PA_W  = PFN_W + OFF_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic [VA_W-1:0]  req_vaddr = '0;
    logic             resp_valid;
    logic [PA_W-1:0]  resp_paddr;
    logic             resp_miss;
    logic             walk_req;
    logic [VPN_W-1:0] walk_vpn;
    logic             walk_ack = 1'b0;
    logic [PFN_W-1:0] walk_pfn = '0;
    logic             flush = 1'b0;
    logic             ev_l1_hit, ev_l2_hit, ev_walk, ev_refill;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    tlb2_top #(
        .VA_W(VA_W), .OFF_W(OFF_W), .PFN_W(PFN_W), .L1_N(L1_N), .L2_N(L2_N)
    ) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .resp_valid(resp_valid), .resp_paddr(resp_paddr), .resp_miss(resp_miss),
        .walk_req(walk_req), .walk_vpn(walk_vpn), .walk_ack(walk_ack), .walk_pfn(walk_pfn),
        .flush(flush),
        .ev_l1_hit(ev_l1_hit), .ev_l2_hit(ev_l2_hit), .ev_walk(ev_walk), .ev_refill(ev_refill)
    );

    // Reference model of both levels, built from the requirements
    logic [VPN_W-1:0] m1_tag [L1_N];
    bit               m1_v   [L1_N];
    int               m1_ptr;
    logic [VPN_W-1:0] m2_tag [L2_N];
    bit               m2_v   [L2_N];
    int               m2_ptr;

    function automatic logic [PFN_W-1:0] pfn_of(input logic [VPN_W-1:0] v);
        return PFN_W'((v * 37) + 5);
    endfunction

    function automatic int find1(input logic [VPN_W-1:0] v);
        for (int i = 0; i < L1_N; i++) if (m1_v[i] && m1_tag[i] == v) return i;
        return -1;
    endfunction

    function automatic int find2(input logic [VPN_W-1:0] v);
        for (int i = 0; i < L2_N; i++) if (m2_v[i] && m2_tag[i] == v) return i;
        return -1;
    endfunction

    task automatic m_clear();
        for (int i = 0; i < L1_N; i++) m1_v[i] = 0;
        for (int i = 0; i < L2_N; i++) m2_v[i] = 0;
    endtask

    task automatic m_put1(input logic [VPN_W-1:0] v);
        int idx = -1;
        for (int i = L1_N - 1; i >= 0; i--) if (!m1_v[i]) idx = i;
        if (idx < 0) begin
            idx = m1_ptr;
            m1_ptr = (m1_ptr + 1) % L1_N;
        end
        m1_v[idx] = 1;
        m1_tag[idx] = v;
    endtask

    task automatic m_put2(input logic [VPN_W-1:0] v);
        int idx = -1;
        for (int i = L2_N - 1; i >= 0; i--) if (!m2_v[i]) idx = i;
        if (idx < 0) begin
            idx = m2_ptr;
            m2_ptr = (m2_ptr + 1) % L2_N;
            for (int j = 0; j < L1_N; j++)
                if (m1_v[j] && m1_tag[j] == m2_tag[idx]) m1_v[j] = 0;
        end
        m2_v[idx] = 1;
        m2_tag[idx] = v;
        m_put1(v);
    endtask

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic do_flush(input string tag);
        @(negedge clk);
        flush = 1'b1;
        #1;
        chk(req_ready == 1'b0, tag, "req_ready during flush", req_ready, 0);
        @(negedge clk);
        flush = 1'b0;
        m_clear();
    endtask

    // One lookup: d = cycles before walk_ack, fd = cycle offset of a flush during the walk (-1 none)
    task automatic look(input logic [VPN_W-1:0] vpn, input logic [OFF_W-1:0] off,
                        input int d, input int fd, input string tag_in);
        int cls, got_n, exp_n, c1, c2, cw, cr, l2_n;
        bit cancel;
        string tag;
        logic [PA_W-1:0] pa;
        logic miss;
        cls = (find1(vpn) >= 0) ? 1 : ((find2(vpn) >= 0) ? 2 : 3);
        if (cls != 3) fd = -1;
        cancel = (cls == 3) && (fd >= 0);
        if (tag_in != "") tag = tag_in;
        else if (cls == 1) tag = "R2";
        else if (cls == 2) tag = "R3";
        else if (cancel) tag = "R8";
        else tag = "R4";
        c1 = 0; c2 = 0; cw = 0; cr = 0; l2_n = 0; got_n = 0; pa = '0; miss = 1'b0;

        @(negedge clk);
        req_vaddr = {vpn, off};
        req_valid = 1'b1;
        #1;
        chk(req_ready == 1'b1, "R9", "req_ready in idle", req_ready, 1);
        @(posedge clk);
        for (int n = 1; n <= 60; n++) begin
            @(negedge clk);
            req_valid = 1'b0;
            if (ev_l1_hit) c1++;
            if (ev_l2_hit) begin c2++; l2_n = n; end
            if (ev_walk) cw++;
            if (ev_refill) cr++;
            if (cls == 3 && n == 1) begin
                chk(walk_req == 1'b1, "R4", "walk_req raised", walk_req, 1);
                chk(walk_vpn == vpn, "R4", "walk_vpn", walk_vpn, vpn);
                chk(req_ready == 1'b0, "R9", "req_ready during walk", req_ready, 0);
            end
            if (resp_valid) begin
                got_n = n;
                pa = resp_paddr;
                miss = resp_miss;
                flush = 1'b0;
                walk_ack = 1'b0;
                break;
            end
            flush    = (cls == 3) && (fd >= 0) && (n == 1 + fd);
            walk_ack = (cls == 3) && (n == 1 + d);
            walk_pfn = pfn_of(vpn);
        end

        exp_n = (cls == 1) ? 1 : ((cls == 2) ? 2 : 2 + d);
        chk(got_n == exp_n, tag, "response latency", got_n, exp_n);
        chk(miss == cancel, tag, "resp_miss", miss, cancel);
        if (!cancel) begin
            chk(pa == {pfn_of(vpn), off}, tag, "resp_paddr", pa, {pfn_of(vpn), off});
            chk(pa[OFF_W-1:0] == off, "R10", "offset pass-through", pa[OFF_W-1:0], off);
        end
        chk(c1 == (cls == 1), tag, "ev_l1_hit count", c1, (cls == 1));
        chk(c2 == (cls == 2), tag, "ev_l2_hit count", c2, (cls == 2));
        if (cls == 2) chk(l2_n == 1, "R3", "ev_l2_hit cycle", l2_n, 1);
        chk(cw == (cls == 3), tag, "ev_walk count", cw, (cls == 3));
        chk(cr == (cls == 3 && !cancel), tag, "ev_refill count", cr, (cls == 3 && !cancel));

        if (cls == 2) m_put1(vpn);
        else if (cls == 3) begin
            if (cancel) m_clear();
            else m_put2(vpn);
        end
    endtask

    task automatic expect_class(input logic [VPN_W-1:0] vpn, input int exp_cls, input string tag);
        int cls;
        cls = (find1(vpn) >= 0) ? 1 : ((find2(vpn) >= 0) ? 2 : 3);
        chk(cls == exp_cls, tag, "model class before lookup", cls, exp_cls);
        look(vpn, OFF_W'(vpn), 1, -1, tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        m_clear();
        m1_ptr = 0;
        m2_ptr = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk(req_ready == 1'b1, "R1", "req_ready after reset", req_ready, 1);
        chk(resp_valid == 1'b0 && walk_req == 1'b0, "R1", "resp/walk after reset",
            {resp_valid, walk_req}, 0);
        chk({ev_l1_hit, ev_l2_hit, ev_walk, ev_refill} == 4'b0, "R1", "events after reset",
            {ev_l1_hit, ev_l2_hit, ev_walk, ev_refill}, 0);
        look(22'd5, 10'h123, 0, -1, "R1");

        // R10: offset extremes on a first-level hit
        look(22'd5, 10'h3FF, 0, -1, "R10");
        look(22'd5, 10'h000, 0, -1, "R10");

        // R7: flush empties both levels
        do_flush("R7");
        expect_class(22'd5, 3, "R7");

        // R5 / R6: fill, round-robin, inclusion
        do_flush("R7");
        for (int v = 0; v < 24; v++) look(VPN_W'(v), 10'h011, 1, -1, "R4");
        expect_class(22'd12, 1, "R5");
        expect_class(22'd5, 2, "R5");
        expect_class(22'd5, 1, "R3");
        expect_class(22'd0, 2, "R5");
        expect_class(22'd24, 3, "R5");
        expect_class(22'd0, 3, "R6");

        // R8: flush during walk, early and in the acknowledge cycle
        look(22'd30, 10'h0AA, 3, 1, "R8");
        expect_class(22'd30, 3, "R8");
        look(22'd31, 10'h055, 2, 2, "R8");
        expect_class(22'd31, 3, "R8");

        // Random mix
        for (int k = 0; k < 600; k++) begin
            int d, fd;
            if ($urandom_range(0, 39) == 0) do_flush("R7");
            d  = $urandom_range(0, 3);
            fd = ($urandom_range(0, 9) == 0) ? $urandom_range(0, d) : -1;
            look(VPN_W'($urandom_range(0, 39)), OFF_W'($urandom), d, fd, "");
        end

        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule